// File: doc/BRIEF.md
# Handshake Bus Read Sequencer

This block carries out single-byte read transfers on an external bus that uses an asynchronous acknowledge handshake. A transfer always walks six phases in a fixed order. It raises a direction line to mark a read, puts the address on the bus, lowers an address strobe and a data strobe together, and waits for the peripheral to pull its acknowledge low. It then latches the byte on the data bus and releases the strobes. If the acknowledge is late, the sequencer stretches the transfer by whole phases until the acknowledge arrives.

Every phase lasts a programmable number of core clocks, set by a divider value that is loaded when the request is accepted. The core side gives a request with an address, a divider and an optional limit on the number of stretch phases. It gets back a one-clock completion pulse with the byte, and a bus-error flag when the limit ran out before the peripheral answered.

Top module: `bus_rd_seq`

## Requirements
- R1: After reset and whenever no transfer runs, `bus_as_no` and `bus_ds_no` are high, `bus_rnw_o` is high, and `busy_o` and `done_o` are low.
- R2: Each phase lasts D core clocks. D is the divider value latched at acceptance. The strobes go low together at the first clock of the third phase, which is clock 2D counted from 0 at the first clock of phase one, and they stay low until the transfer completes.
- R3: `bus_addr_o` reads 0 during the first phase. From clock D on, it carries the accepted address unchanged until completion, and it returns to 0 when idle.
- R4: `bus_rnw_o` is high at all times.
- R5: The acknowledge (`bus_dtack_ni` low) counts for the fifth phase, or for a stretch phase, only if it is low on the core clock before the last clock of that phase. Otherwise a stretch phase of exactly D clocks follows and the check repeats. After the check succeeds, one more phase of D clocks ends the transfer.
- R6: With D = 1, the acknowledge for a checking phase is sampled on the last clock of the phase before it.
- R7: The data bus is latched on the last clock of the final phase. In the next clock, `done_o` is high for exactly one clock, `rdata_o` holds the byte, and the strobes are high again.
- R8: A request is accepted only while `busy_o` is low. `busy_o` is high from the clock after acceptance until completion. A request that arrives while busy has no effect on the running transfer.
- R9: A nonzero `wait_lim_i` caps the number of stretch phases. If the acknowledge is still missing when the cap is reached, the transfer ends through the final phase, `berr_o` is high with `done_o`, and `rdata_o` is 0. A value of 0 means no cap, and then `berr_o` is low at completion.
- R10: A divider value of 0 is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | start a read (accepted only while idle) |
| addr_i | input | 24 | read address |
| div_i | input | 4 | core clocks per phase (0 is taken as 1) |
| wait_lim_i | input | 4 | maximum number of stretch phases, 0 = no cap |
| busy_o | output | 1 | transfer in progress |
| done_o | output | 1 | one-clock completion pulse |
| rdata_o | output | 8 | latched byte (0 on bus error) |
| berr_o | output | 1 | transfer ended because the stretch cap ran out |
| bus_rnw_o | output | 1 | bus direction, high = read |
| bus_addr_o | output | 24 | bus address |
| bus_as_no | output | 1 | address strobe, active low |
| bus_ds_no | output | 1 | data strobe, active low |
| bus_dtack_ni | input | 1 | peripheral acknowledge, active low |
| bus_data_i | input | 8 | bus data |

## Verification
The bench keeps the default widths: a 24-bit address, an 8-bit byte and 4-bit divider and limit fields. It varies the divider at run time over 0, 1, 2, 3, 4 and 15. This covers the single-clock phase case, in which sampling moves into the previous phase, and the longest phase, in which the clock-before-last sampling point sits deep inside the phase. The acknowledge is placed on the exact deadline clock and one clock after it, to pin the sampling point. The 4-bit limit field allows caps small enough that a missing acknowledge reaches the bus-error path within a few phases.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P0   = 3'd1,
    ST_P1   = 3'd2,
    ST_P2   = 3'd3,
    ST_P3   = 3'd4,
    ST_P4   = 3'd5,
    ST_WAIT = 3'd6,
    ST_P5   = 3'd7
  } rd_state_e;
endpackage

// File: rtl/bus_rd_timer.sv
// phase timer: counts core clocks inside one bus phase
module bus_rd_timer #(
  parameter int DIVW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            run_i,
  output logic            last_o,
  output logic            prelast_o,
  output logic            unit_o
);
  logic [DIVW-1:0] div_q, cnt_q;

  assign last_o    = (cnt_q == div_q - DIVW'(1));
  assign unit_o    = (div_q == DIVW'(1));
  assign prelast_o = !unit_o && (cnt_q == div_q - DIVW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIVW'(1);
      cnt_q <= '0;
    end else begin
      if (load_i) div_q <= (div_i == '0) ? DIVW'(1) : div_i;
      if (!run_i || last_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + DIVW'(1);
    end
  end
endmodule

// File: rtl/bus_rd_ack.sv
// acknowledge sampler and stretch-phase counter
module bus_rd_ack #(
  parameter int WLW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [WLW-1:0] lim_i,
  input  logic           sample_i,
  input  logic           dtack_ni,
  input  logic           wait_inc_i,
  output logic           ack_o,
  output logic           lim_hit_o
);
  logic [WLW-1:0] lim_q, wcnt_q;

  assign lim_hit_o = (lim_q != '0) && (wcnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '0;
      wcnt_q <= '0;
      ack_o  <= 1'b0;
    end else if (load_i) begin
      lim_q  <= lim_i;
      wcnt_q <= '0;
      ack_o  <= 1'b0;
    end else begin
      if (sample_i)   ack_o  <= !dtack_ni;
      if (wait_inc_i) wcnt_q <= wcnt_q + WLW'(1);
    end
  end
endmodule

// File: rtl/bus_rd_capture.sv
// result register: data, error flag, completion pulse
module bus_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          berr_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          berr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
      berr_o  <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        rdata_o <= berr_i ? '0 : data_i;
        berr_o  <= berr_i;
      end
    end
  end
endmodule

// File: rtl/bus_rd_seq.sv
module bus_rd_seq
  import bus_rd_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 8,
  parameter int DIVW = 4,
  parameter int WLW  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [WLW-1:0]  wait_lim_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o,
  output logic            berr_o,
  output logic            bus_rnw_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic            bus_as_no,
  output logic            bus_ds_no,
  input  logic            bus_dtack_ni,
  input  logic [DW-1:0]   bus_data_i
);
  rd_state_e state_q, state_d;
  logic [AW-1:0] addr_q;
  logic err_q, err_set;
  logic load, run, last, prelast, unit;
  logic is_chk, sample, ack, lim_hit, wait_inc, fire;

  assign load   = (state_q == ST_IDLE) && req_i;
  assign run    = (state_q != ST_IDLE);
  assign is_chk = (state_q == ST_P4) || (state_q == ST_WAIT);
  // single-clock phases sample on the last clock of the phase before
  assign sample = (is_chk && prelast) ||
                  (unit && last && (is_chk || state_q == ST_P3));

  bus_rd_timer #(.DIVW(DIVW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .div_i, .run_i(run),
    .last_o(last), .prelast_o(prelast), .unit_o(unit)
  );

  bus_rd_ack #(.WLW(WLW)) u_ack (
    .clk_i, .rst_ni, .load_i(load), .lim_i(wait_lim_i), .sample_i(sample),
    .dtack_ni(bus_dtack_ni), .wait_inc_i(wait_inc), .ack_o(ack),
    .lim_hit_o(lim_hit)
  );

  bus_rd_capture #(.DW(DW)) u_cap (
    .clk_i, .rst_ni, .fire_i(fire), .berr_i(err_q), .data_i(bus_data_i),
    .done_o, .rdata_o, .berr_o
  );

  always_comb begin
    state_d  = state_q;
    wait_inc = 1'b0;
    err_set  = 1'b0;
    fire     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_P0;
      ST_P0:   if (last) state_d = ST_P1;
      ST_P1:   if (last) state_d = ST_P2;
      ST_P2:   if (last) state_d = ST_P3;
      ST_P3:   if (last) state_d = ST_P4;
      ST_P4, ST_WAIT: begin
        if (last) begin
          if (ack) state_d = ST_P5;
          else if (lim_hit) begin
            state_d = ST_P5;
            err_set = 1'b1;
          end else begin
            state_d  = ST_WAIT;
            wait_inc = 1'b1;
          end
        end
      end
      ST_P5: begin
        if (last) begin
          state_d = ST_IDLE;
          fire    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        addr_q <= addr_i;
        err_q  <= 1'b0;
      end else if (err_set) begin
        err_q <= 1'b1;
      end
    end
  end

  logic strobe;
  assign strobe     = (state_q == ST_P2) || (state_q == ST_P3) || is_chk ||
                      (state_q == ST_P5);
  assign bus_as_no  = !strobe;
  assign bus_ds_no  = !strobe;
  assign bus_addr_o = (run && state_q != ST_P0) ? addr_q : '0;
  assign bus_rnw_o  = 1'b1;
  assign busy_o     = run;
endmodule

// File: rtl/bus_rd_seq_chk.sv
module bus_rd_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic          berr_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_as_no,
  input logic          bus_ds_no
);
  assert_idle_strobes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_as_no && bus_ds_no));
  assert_strobes_paired_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_as_no == bus_ds_no);
  assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_as_no && busy_o) |-> $stable(bus_addr_o));
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_release_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_as_no) |-> done_o);
  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_accept_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);
  assert_err_zero_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && berr_o) |-> (rdata_o == '0));
endmodule

bind bus_rd_seq bus_rd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .done_o(done_o), .rdata_o(rdata_o), .berr_o(berr_o),
  .bus_addr_o(bus_addr_o), .bus_as_no(bus_as_no), .bus_ds_no(bus_ds_no)
);

// File: tb/bus_rd_seq_bench.sv
`timescale 1ns/1ps
module bus_rd_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, dtack_n = 1'b1;
  logic [23:0] addr = '0;
  logic [3:0] div = '0, lim = '0;
  logic [7:0] bdata = '0;
  logic busy, done, berr, rnw, as_n, ds_n;
  logic [7:0] rdata;
  logic [23:0] baddr;
  int checks = 0, errors = 0;

  always #10 clk = !clk;

  bus_rd_seq u_bus_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .div_i(div),
    .wait_lim_i(lim), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .berr_o(berr), .bus_rnw_o(rnw), .bus_addr_o(baddr), .bus_as_no(as_n),
    .bus_ds_no(ds_n), .bus_dtack_ni(dtack_n), .bus_data_i(bdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // a: first clock (from 0 = first clock of phase one) with acknowledge low
  task automatic run(input int d, input int a, input int lv, input logic [23:0] ad,
                     input logic [7:0] dv, input bit poke, input string tg);
    int de, n, len;
    bit err;
    de = (d == 0) ? 1 : d;
    n = 0;
    while (a > 5*de + n*de - 2) n++;
    err = (lv != 0) && (n > lv);
    if (err) n = lv;
    len = 6*de + n*de;
    @(negedge clk);
    chk(!busy, "R8 idle before request", busy, 0);
    req = 1'b1; addr = ad; div = 4'(d); lim = 4'(lv); dtack_n = 1'b1; bdata = ~dv;
    @(negedge clk);
    req = 1'b0; addr = '0;
    for (int i = 0; i <= len; i++) begin
      if (i < len) begin
        chk(busy == 1'b1, "R8 busy", busy, 1);
        chk(as_n == !(i >= 2*de), "R2 address strobe", as_n, !(i >= 2*de));
        chk(ds_n == as_n, "R2 data strobe", ds_n, as_n);
        chk(baddr == ((i >= de) ? ad : 24'h0), "R3 address", baddr, (i >= de) ? ad : 24'h0);
        chk(rnw == 1'b1, "R4 direction", rnw, 1);
        chk(done == 1'b0, {tg, " early done"}, done, 0);
      end else begin
        chk(done == 1'b1, {tg, " done timing"}, done, 1);
        chk(!busy && as_n && ds_n, "R7 release", {busy, as_n, ds_n}, 3'b011);
        chk(rdata == (err ? 8'h00 : dv), "R7 R9 read data", rdata, err ? 8'h00 : dv);
        chk(berr == err, "R9 error flag", berr, err);
        chk(baddr == 24'h0, "R3 idle address", baddr, 0);
      end
      dtack_n = (i >= a) ? 1'b0 : 1'b1;
      bdata = (i == len - 1) ? dv : ~dv;
      if (poke && i == 3) begin req = 1'b1; addr = ~ad; end
      else begin req = 1'b0; addr = '0; end
      @(negedge clk);
    end
    chk(done == 1'b0, "R7 single pulse", done, 0);
    chk(!busy, "R8 stays idle", busy, 0);
    dtack_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(as_n && ds_n && rnw, "R1 reset strobes", {as_n, ds_n, rnw}, 3'b111);
    chk(!busy && !done, "R1 reset status", {busy, done}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && !busy && !done, "R1 idle after reset", {as_n, busy, done}, 3'b100);
    run(3, 0, 0, 24'h123456, 8'hA5, 1'b0, "R5");      // early acknowledge
    run(4, 18, 0, 24'hABCDEF, 8'h3C, 1'b0, "R5");     // on the deadline clock
    run(4, 19, 0, 24'h000001, 8'h5A, 1'b1, "R5 R8");  // one late: one stretch, mid-cycle request
    run(1, 3, 0, 24'hFFFFFF, 8'h81, 1'b0, "R6");      // sampled in previous phase
    run(1, 4, 0, 24'h800000, 8'h7E, 1'b0, "R6");
    run(2, 20, 0, 24'h0F0F0F, 8'hC3, 1'b0, "R5");     // several stretch phases
    run(3, 10000, 2, 24'h111111, 8'hEE, 1'b0, "R9");  // cap reached
    run(2, 11, 3, 24'h222222, 8'h99, 1'b0, "R9");     // answered under the cap
    run(0, 3, 0, 24'h333333, 8'h42, 1'b0, "R10");     // zero divider as 1
    run(0, 4, 0, 24'h444444, 8'h24, 1'b0, "R10");
    run(15, 0, 0, 24'h555555, 8'h18, 1'b1, "R2 R8");  // longest phase
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule